// File: doc/BRIEF.md
# Nibble-Addressed PSRAM Bus Bridge

This block connects an 8-bit asynchronous host bus to two external pseudo-static RAM banks of 8 MB each. The host drives active-low read and write strobes, one mode line and one active-low select line per bank. The bridge moves every host bus event into its own clock domain through two-stage synchronisers. It acts on the falling edge of each strobe, so a long strobe still causes only one action.

With the mode line high the host enters a 24-bit start address as six 4-bit writes, most significant nibble first. With the mode line low each write stores one byte and each read fetches one byte. The per-bank address counter steps after every access, so a whole block moves after a single address load. Reads are pipelined. A read hands the host the byte that the previous read fetched, and then fetches the next one. The host therefore issues one throw-away read after each address load.

Each bank has its own address register and its own prefetch latch. Transfers to the two banks can be interleaved without one disturbing the other. On the memory side the bridge drives an SRAM-style interface: one chip enable per bank, shared output enable and write enable, and shared address and data lines. Each access lasts exactly one bridge clock.

Top module: `psram_nibble_bridge`

## Requirements
- R1: After reset all chip enables, output enable and write enable are high (inactive), and host_d_o is 0x00.
- R2: With host_amode = 1, each host write shifts host_d_i[3:0] into the selected bank's 24-bit address from the low end, so six writes load the address most significant nibble first. host_d_i[7:4] is ignored.
- R3: Only six nibble writes are accepted per address session. Further address-mode writes are ignored until host_amode rises again or all selects go high.
- R4: A data-mode write (host_amode = 0) produces exactly one clock of mem_ce_n[unit] = 0 and mem_we_n = 0, with mem_oe_n = 1. mem_a carries the bank's current address and mem_d_o carries the host byte.
- R5: The bank's address steps by one after every data-mode read or write and wraps from 0xFFFFFF to 0x000000. A bank decodes mem_a[22:0].
- R6: A data-mode read puts the bank's prefetch latch on host_d_o, then reads the bank at its current address into that latch. The first read after an address load therefore returns the stale latch (0x00 after reset).
- R7: Each bank keeps its own address and prefetch latch, so accesses to one bank leave the other bank's transfer state unchanged.
- R8: A strobe while both selects are high causes no memory cycle and no address change.
- R9: When both selects are low, bank 0 (host_sel_n[0]) is used.
- R10: One strobe produces one action, however long it is held low.
- R11: A read strobe in address mode causes no memory cycle and leaves host_d_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_d_i | input | 8 | Host write data (nibble in bits 3:0 in address mode) |
| host_d_o | output | 8 | Host read data, held between reads |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_amode | input | 1 | 1 = address load, 0 = data transfer |
| host_sel_n | input | 2 | Per-bank select, active low, bit 0 has priority |
| mem_ce_n | output | 2 | Per-bank chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_a | output | 24 | Byte address of the access |
| mem_d_o | output | 8 | Write data to memory |
| mem_d_i | input | 8 | Read data from memory |

## Verification
The hardest state to reach from the ports is a nibble counter that has been cleared by a deselect rather than by a mode rise. The stimulus reaches it by writing three nibbles, dropping both selects while address mode stays high, and then writing six more nibbles. Only if the counter was cleared does the later data write land at the intended address. The pipelined-read skew across interleaved banks is also hard to reach. A vector table loads and reads both banks alternately, so each bank's returned byte shows the other bank's accesses did not disturb it. Strobes held for many clocks check that one strobe yields one memory pulse.

// File: rtl/psb_pkg.sv
package psb_pkg;
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACCESS = 1'b1
    } psb_state_e;
endpackage

// File: rtl/psb_sync.sv
module psb_sync #(
    parameter int             W       = 4,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] sync;
    } sync_t;

    sync_t sd_d, sd_q;

    always_comb begin
        sd_d      = sd_q;
        sd_d.meta = async_i;
        sd_d.sync = sd_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sd_q <= '{meta: RST_VAL, sync: RST_VAL};
        end else begin
            sd_q <= sd_d;
        end
    end

    assign sync_o = sd_q.sync;
endmodule

// File: rtl/psb_unit.sv
module psb_unit #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nib_we,
    input  logic [NIB_W-1:0]  nib,
    input  logic              inc,
    input  logic              pf_we,
    input  logic [DATA_W-1:0] pf_din,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] pf_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] pf;
    } unit_t;

    unit_t u_d, u_q;

    always_comb begin
        u_d = u_q;
        if (nib_we) begin
            u_d.addr = {u_q.addr[ADDR_W-NIB_W-1:0], nib};
        end else if (inc) begin
            u_d.addr = u_q.addr + 1'b1;
        end
        if (pf_we) begin
            u_d.pf = pf_din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            u_q <= '0;
        end else begin
            u_q <= u_d;
        end
    end

    assign addr_o = u_q.addr;
    assign pf_o   = u_q.pf;

    // R2: a nibble enters at the low end and older nibbles move up
    a_r2_nibble_shift: assert property (@(posedge clk) disable iff (!rst_n)
        nib_we |=> (u_q.addr[NIB_W-1:0] == $past(nib)) &&
                   (u_q.addr[ADDR_W-1:NIB_W] == $past(u_q.addr[ADDR_W-NIB_W-1:0])));

    // R5: a completed access steps the address by one, wrapping naturally
    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !nib_we) |=> u_q.addr == $past(u_q.addr) + 1'b1);

    // R7: without a request for this unit its address holds
    a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !nib_we) |=> $stable(u_q.addr));

    // R7: the prefetch latch only moves on its own fetch
    a_r7_pf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pf_we |=> $stable(u_q.pf));
endmodule

// File: rtl/psb_ctrl.sv
module psb_ctrl
    import psb_pkg::*;
#(
    parameter int NU     = 2,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_n_s,
    input  logic                        wr_n_s,
    input  logic                        amode_s,
    input  logic [NU-1:0]               sel_n_s,
    input  logic [DATA_W-1:0]           host_d_i,
    input  logic [NU-1:0][ADDR_W-1:0]   unit_addr,
    input  logic [NU-1:0][DATA_W-1:0]   unit_pf,
    input  logic [DATA_W-1:0]           mem_d_i,
    output logic [NU-1:0]               nib_we,
    output logic [NIB_W-1:0]            nib,
    output logic [NU-1:0]               inc,
    output logic [NU-1:0]               pf_we,
    output logic [DATA_W-1:0]           pf_din,
    output logic [DATA_W-1:0]           host_d_o,
    output logic [NU-1:0]               mem_ce_n,
    output logic                        mem_oe_n,
    output logic                        mem_we_n,
    output logic [ADDR_W-1:0]           mem_a,
    output logic [DATA_W-1:0]           mem_d_o
);
    localparam int NIBS   = ADDR_W / NIB_W;
    localparam int CNT_W  = $clog2(NIBS + 1);
    localparam int UIDX_W = (NU > 1) ? $clog2(NU) : 1;

    typedef struct packed {
        logic                rd_prev;
        logic                wr_prev;
        logic                amode_prev;
        logic [CNT_W-1:0]    cnt;
        psb_state_e          st;
        logic [UIDX_W-1:0]   acc_unit;
        logic                acc_rd;
        logic [NU-1:0]       ce_n;
        logic                oe_n;
        logic                we_n;
        logic [ADDR_W-1:0]   a;
        logic [DATA_W-1:0]   wd;
        logic [DATA_W-1:0]   dout;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic              hit;
    logic [UIDX_W-1:0] uidx;
    logic              rd_ev;
    logic              wr_ev;
    logic              mode_rise;

    // Select decode: lowest-numbered active select wins
    always_comb begin
        hit  = 1'b0;
        uidx = '0;
        for (int i = NU - 1; i >= 0; i--) begin
            if (!sel_n_s[i]) begin
                hit  = 1'b1;
                uidx = UIDX_W'(i);
            end
        end
    end

    assign rd_ev     = c_q.rd_prev & ~rd_n_s;
    assign wr_ev     = c_q.wr_prev & ~wr_n_s;
    assign mode_rise = ~c_q.amode_prev & amode_s;

    always_comb begin
        c_d            = c_q;
        c_d.rd_prev    = rd_n_s;
        c_d.wr_prev    = wr_n_s;
        c_d.amode_prev = amode_s;

        nib_we = '0;
        inc    = '0;
        pf_we  = '0;
        nib    = host_d_i[NIB_W-1:0];
        pf_din = mem_d_i;

        // Address-load session bookkeeping
        if (mode_rise || !hit) begin
            c_d.cnt = '0;
        end else if (amode_s && wr_ev && (c_q.cnt < CNT_W'(NIBS))) begin
            c_d.cnt      = c_q.cnt + 1'b1;
            nib_we[uidx] = 1'b1;
        end

        unique case (c_q.st)
            ST_IDLE: begin
                if (hit && !amode_s && (rd_ev || wr_ev)) begin
                    c_d.st             = ST_ACCESS;
                    c_d.acc_unit       = uidx;
                    c_d.acc_rd         = rd_ev;
                    c_d.ce_n           = '1;
                    c_d.ce_n[uidx]     = 1'b0;
                    c_d.oe_n           = ~rd_ev;
                    c_d.we_n           = rd_ev;
                    c_d.a              = unit_addr[uidx];
                    c_d.wd             = host_d_i;
                    if (rd_ev) begin
                        c_d.dout = unit_pf[uidx];
                    end
                end
            end
            ST_ACCESS: begin
                inc[c_q.acc_unit]   = 1'b1;
                pf_we[c_q.acc_unit] = c_q.acc_rd;
                c_d.st              = ST_IDLE;
                c_d.ce_n            = '1;
                c_d.oe_n            = 1'b1;
                c_d.we_n            = 1'b1;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q            <= '0;
            c_q.rd_prev    <= 1'b1;
            c_q.wr_prev    <= 1'b1;
            c_q.amode_prev <= 1'b0;
            c_q.st         <= ST_IDLE;
            c_q.ce_n       <= '1;
            c_q.oe_n       <= 1'b1;
            c_q.we_n       <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign host_d_o = c_q.dout;
    assign mem_ce_n = c_q.ce_n;
    assign mem_oe_n = c_q.oe_n;
    assign mem_we_n = c_q.we_n;
    assign mem_a    = c_q.a;
    assign mem_d_o  = c_q.wd;

    // R4: never more than one bank enabled
    a_r4_ce_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~c_q.ce_n));

    // R4: read and write enables never overlap
    a_r4_oe_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!c_q.oe_n && !c_q.we_n));

    // R4: a write pulse lasts one clock
    a_r4_we_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        !c_q.we_n |=> c_q.we_n);

    // R10: a read pulse lasts one clock
    a_r10_oe_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        !c_q.oe_n |=> c_q.oe_n);

    // R3: the nibble count never passes one full address
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.cnt <= CNT_W'(NIBS));

    // R8: idle with nothing selected keeps every bank disabled
    a_r8_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_IDLE && !hit) |=> c_q.ce_n == '1);

    // R6: host read data changes only after a read strobe edge
    a_r6_dout_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.dout != $past(c_q.dout)) |-> $past(rd_ev));
endmodule

// File: rtl/psram_nibble_bridge.sv
module psram_nibble_bridge #(
    parameter int NUM_UNITS = 2,
    parameter int ADDR_W    = 24,
    parameter int DATA_W    = 8,
    parameter int NIB_W     = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DATA_W-1:0]     host_d_i,
    output logic [DATA_W-1:0]     host_d_o,
    input  logic                  host_rd_n,
    input  logic                  host_wr_n,
    input  logic                  host_amode,
    input  logic [NUM_UNITS-1:0]  host_sel_n,
    output logic [NUM_UNITS-1:0]  mem_ce_n,
    output logic                  mem_oe_n,
    output logic                  mem_we_n,
    output logic [ADDR_W-1:0]     mem_a,
    output logic [DATA_W-1:0]     mem_d_o,
    input  logic [DATA_W-1:0]     mem_d_i
);
    localparam int SW = NUM_UNITS + 3;
    localparam logic [SW-1:0] SYNC_RST = {{NUM_UNITS{1'b1}}, 1'b0, 1'b1, 1'b1};

    logic [SW-1:0]                   sync_s;
    logic                            rd_n_s;
    logic                            wr_n_s;
    logic                            amode_s;
    logic [NUM_UNITS-1:0]            sel_n_s;
    logic [NUM_UNITS-1:0]            nib_we;
    logic [NIB_W-1:0]                nib;
    logic [NUM_UNITS-1:0]            inc;
    logic [NUM_UNITS-1:0]            pf_we;
    logic [DATA_W-1:0]               pf_din;
    logic [NUM_UNITS-1:0][ADDR_W-1:0] unit_addr;
    logic [NUM_UNITS-1:0][DATA_W-1:0] unit_pf;

    psb_sync #(
        .W       (SW),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({host_sel_n, host_amode, host_wr_n, host_rd_n}),
        .sync_o  (sync_s)
    );

    assign rd_n_s  = sync_s[0];
    assign wr_n_s  = sync_s[1];
    assign amode_s = sync_s[2];
    assign sel_n_s = sync_s[SW-1:3];

    psb_ctrl #(
        .NU     (NUM_UNITS),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NIB_W  (NIB_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_n_s    (rd_n_s),
        .wr_n_s    (wr_n_s),
        .amode_s   (amode_s),
        .sel_n_s   (sel_n_s),
        .host_d_i  (host_d_i),
        .unit_addr (unit_addr),
        .unit_pf   (unit_pf),
        .mem_d_i   (mem_d_i),
        .nib_we    (nib_we),
        .nib       (nib),
        .inc       (inc),
        .pf_we     (pf_we),
        .pf_din    (pf_din),
        .host_d_o  (host_d_o),
        .mem_ce_n  (mem_ce_n),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_a     (mem_a),
        .mem_d_o   (mem_d_o)
    );

    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
        psb_unit #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .NIB_W  (NIB_W)
        ) u_unit (
            .clk    (clk),
            .rst_n  (rst_n),
            .nib_we (nib_we[g]),
            .nib    (nib),
            .inc    (inc[g]),
            .pf_we  (pf_we[g]),
            .pf_din (pf_din),
            .addr_o (unit_addr[g]),
            .pf_o   (unit_pf[g])
        );
    end
endmodule

// File: tb/psram_nibble_bridge_bench.sv
module psram_nibble_bridge_bench;
    localparam int MODEL_AW = 10;
    localparam int NV       = 24;
    localparam logic [1:0] OP_LDA = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2, OP_MEM = 2'd3;
    localparam logic [1:0] U0 = 2'b10, U1 = 2'b01;

    // {op, sel_n, value, expected}
    localparam logic [35:0] VECS [0:NV-1] = '{
        {OP_LDA, U0, 24'h000010, 8'h00},   // R2 load bank 0
        {OP_WR,  U0, 24'h0000A1, 8'h00},   // R4
        {OP_WR,  U0, 24'h0000B2, 8'h00},
        {OP_WR,  U0, 24'h0000C3, 8'h00},
        {OP_MEM, U0, 24'h000010, 8'hA1},   // R4 byte landed at start address
        {OP_MEM, U0, 24'h000012, 8'hC3},   // R5 address stepped twice
        {OP_LDA, U0, 24'h000010, 8'h00},
        {OP_RD,  U0, 24'h000000, 8'h00},   // R6 stale latch
        {OP_RD,  U0, 24'h000000, 8'hA1},   // R6 first real byte
        {OP_LDA, U1, 24'h000020, 8'h00},
        {OP_WR,  U1, 24'h000055, 8'h00},
        {OP_WR,  U1, 24'h000066, 8'h00},
        {OP_MEM, U1, 24'h000020, 8'h55},   // R7 bank 1 written
        {OP_RD,  U0, 24'h000000, 8'hB2},   // R7 bank 0 state survived
        {OP_LDA, U1, 24'h000020, 8'h00},
        {OP_RD,  U1, 24'h000000, 8'h00},   // R6 bank 1 stale latch
        {OP_RD,  U1, 24'h000000, 8'h55},
        {OP_RD,  U0, 24'h000000, 8'hC3},   // R7
        {OP_LDA, U0, 24'hFFFFFF, 8'h00},
        {OP_WR,  U0, 24'h000077, 8'h00},
        {OP_WR,  U0, 24'h000088, 8'h00},
        {OP_MEM, U0, 24'h0003FF, 8'h77},   // R5 top of space
        {OP_MEM, U0, 24'h000000, 8'h88},   // R5 wrapped to zero
        {OP_RD,  U1, 24'h000000, 8'h66}    // R6 bank 1 prefetch
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  host_d_i = 8'h00;
    logic [7:0]  host_d_o;
    logic        host_rd_n = 1'b1;
    logic        host_wr_n = 1'b1;
    logic        host_amode = 1'b0;
    logic [1:0]  host_sel_n = 2'b11;
    logic [1:0]  mem_ce_n;
    logic        mem_oe_n;
    logic        mem_we_n;
    logic [23:0] mem_a;
    logic [7:0]  mem_d_o;
    logic [7:0]  mem_d_i;

    logic [7:0] bank0 [0:(1<<MODEL_AW)-1];
    logic [7:0] bank1 [0:(1<<MODEL_AW)-1];
    int we_cnt0 = 0, we_cnt1 = 0, oe_cnt0 = 0, oe_cnt1 = 0;
    int we_run = 0, we_run_max = 0;
    int n_cmp = 0, n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    psram_nibble_bridge u_psram_nibble_bridge (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_d_i   (host_d_i),
        .host_d_o   (host_d_o),
        .host_rd_n  (host_rd_n),
        .host_wr_n  (host_wr_n),
        .host_amode (host_amode),
        .host_sel_n (host_sel_n),
        .mem_ce_n   (mem_ce_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_a      (mem_a),
        .mem_d_o    (mem_d_o),
        .mem_d_i    (mem_d_i)
    );

    // Memory model: asynchronous read, write at the clock edge
    always_comb begin
        mem_d_i = 8'h00;
        if (!mem_oe_n && !mem_ce_n[0]) mem_d_i = bank0[mem_a[MODEL_AW-1:0]];
        else if (!mem_oe_n && !mem_ce_n[1]) mem_d_i = bank1[mem_a[MODEL_AW-1:0]];
    end

    always @(posedge clk) begin
        if (rst_n) begin
            if (!mem_we_n && !mem_ce_n[0]) begin
                bank0[mem_a[MODEL_AW-1:0]] <= mem_d_o;
                we_cnt0 <= we_cnt0 + 1;
            end
            if (!mem_we_n && !mem_ce_n[1]) begin
                bank1[mem_a[MODEL_AW-1:0]] <= mem_d_o;
                we_cnt1 <= we_cnt1 + 1;
            end
            if (!mem_oe_n && !mem_ce_n[0]) oe_cnt0 <= oe_cnt0 + 1;
            if (!mem_oe_n && !mem_ce_n[1]) oe_cnt1 <= oe_cnt1 + 1;
            if (!mem_we_n) begin
                we_run <= we_run + 1;
                if (we_run + 1 > we_run_max) we_run_max <= we_run + 1;
            end else begin
                we_run <= 0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic set_bus(input logic m, input logic [1:0] s);
        @(negedge clk);
        host_amode = m;
        host_sel_n = s;
        repeat (4) @(negedge clk);
    endtask

    task automatic wr_strobe(input logic [7:0] v);
        @(negedge clk);
        host_d_i  = v;
        host_wr_n = 1'b0;
        repeat (5) @(negedge clk);
        host_wr_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic rd_strobe(input int hold, output logic [7:0] v);
        @(negedge clk);
        host_rd_n = 1'b0;
        repeat (hold) @(negedge clk);
        v = host_d_o;
        host_rd_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    // Six nibbles, high nibble first, with junk in bits 7:4 (R2)
    task automatic load_addr(input logic [1:0] s, input logic [23:0] a, input int extra);
        set_bus(1'b0, s);
        set_bus(1'b1, s);
        for (int k = 5; k >= 0; k--) wr_strobe({4'hA, a[4*k +: 4]});
        for (int e = 0; e < extra; e++) wr_strobe(8'hAF);
        set_bus(1'b0, s);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] rv;
        int c0, c1, o1;
        for (int i = 0; i < (1 << MODEL_AW); i++) begin
            bank0[i] = 8'h00;
            bank1[i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ce_n", {30'd0, mem_ce_n}, 32'h3);
        chk("R1 oe_n/we_n", {30'd0, mem_oe_n, mem_we_n}, 32'h3);
        chk("R1 host_d_o", {24'd0, host_d_o}, 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            logic [1:0]  op;
            logic [1:0]  sl;
            logic [23:0] val;
            logic [7:0]  ex;
            {op, sl, val, ex} = VECS[v];
            case (op)
                OP_LDA: load_addr(sl, val, 0);
                OP_WR: begin
                    set_bus(1'b0, sl);
                    wr_strobe(val[7:0]);
                end
                OP_RD: begin
                    set_bus(1'b0, sl);
                    rd_strobe(6, rv);
                    chk($sformatf("R6/R7 vector %0d read", v), {24'd0, rv}, {24'd0, ex});
                end
                default: begin
                    if (sl == U0) chk($sformatf("R4/R5 vector %0d bank0", v),
                                      {24'd0, bank0[val[MODEL_AW-1:0]]}, {24'd0, ex});
                    else          chk($sformatf("R4/R5 vector %0d bank1", v),
                                      {24'd0, bank1[val[MODEL_AW-1:0]]}, {24'd0, ex});
                end
            endcase
        end

        // R3: extra nibbles after six are ignored
        load_addr(U0, 24'h000100, 2);
        wr_strobe(8'h99);
        chk("R3 extra nibbles ignored", {24'd0, bank0[10'h100]}, 32'h99);

        // R3: deselect clears the nibble count while address mode stays high
        set_bus(1'b0, U0);
        set_bus(1'b1, U0);
        for (int k = 0; k < 3; k++) wr_strobe(8'h0F);
        set_bus(1'b1, 2'b11);
        set_bus(1'b1, U0);
        for (int k = 5; k >= 0; k--) wr_strobe({4'h0, 24'h000200 >> (4 * k)} & 8'h0F);
        set_bus(1'b0, U0);
        wr_strobe(8'h5A);
        chk("R3 deselect restarts nibble count", {24'd0, bank0[10'h200]}, 32'h5A);

        // R9: both selects low picks bank 0
        load_addr(U0, 24'h000300, 0);
        c1 = we_cnt1;
        set_bus(1'b0, 2'b00);
        wr_strobe(8'h6B);
        chk("R9 bank0 written", {24'd0, bank0[10'h300]}, 32'h6B);
        chk("R9 bank1 untouched", we_cnt1 - c1, 0);

        // R8: deselected strobe ignored, address not stepped
        c0 = we_cnt0;
        c1 = we_cnt1;
        set_bus(1'b0, 2'b11);
        wr_strobe(8'h11);
        chk("R8 no memory cycle", (we_cnt0 - c0) + (we_cnt1 - c1), 0);
        set_bus(1'b0, U0);
        wr_strobe(8'h22);
        chk("R8 address unchanged", {24'd0, bank0[10'h301]}, 32'h22);

        // R10: a long read strobe makes one access
        load_addr(U1, 24'h000020, 0);
        o1 = oe_cnt1;
        rd_strobe(40, rv);
        chk("R10 one read pulse", oe_cnt1 - o1, 1);
        rd_strobe(6, rv);
        chk("R10 next read returns following byte", {24'd0, rv}, 32'h55);

        // R11: read in address mode is ignored
        o1 = oe_cnt0 + oe_cnt1;
        set_bus(1'b1, U1);
        rd_strobe(6, rv);
        chk("R11 no read pulse", (oe_cnt0 + oe_cnt1) - o1, 0);
        chk("R11 host_d_o held", {24'd0, rv}, 32'h55);
        set_bus(1'b0, U1);

        // R4: write pulses never last more than one clock
        chk("R4 write pulse width", we_run_max, 1);

        finish_run();
    end
endmodule